// File: doc/BRIEF.md
# Periodic Block Displacement Address Remapper

This block sits on a linear physical address path and rearranges memory at block granularity. When the enable bit in the page flags that come with an address is set, the address is split into a block index and an in-block offset. The block index is then moved forward or backward by a signed number of block positions. The amount of that move comes from a short signed sequence that repeats along the address space. When the enable bit is clear, the address passes through untouched.

A two-bit profile select chooses one of four profiles. Each profile fixes the block size and the displacement sequence. Three of the block sizes are powers of two. The fourth is seven 4 KiB pages, so its block index needs a real division by a constant.

Every address takes the same three register stages, whatever the profile. The pipeline accepts a new address on every clock. If a displaced block would land outside the address space, below zero or above the top, the block raises an error flag and returns the original address.

Top module: `blkmap_top`

## Requirements
- R1: When bit 11 of `in_flags` (mask 0x0800) is 0, `out_addr` equals the input address and `out_err` is 0, whatever the other flag bits and the profile are.
- R2: `in_prof` selects the block size: 0 gives 0x2000 bytes, 1 gives 0x4000, 2 gives 0x7000 and 3 gives 0x8000. A remapped address differs from its input by a whole number of blocks of that size.
- R3: Profiles 0 and 3 use the 12-entry displacement sequence +1 -1 +1 -1 +1 -1 +2 +3 -2 +2 -3 -2. Entry 0 is the displacement for phase 0.
- R4: Profile 1 uses the 12-entry sequence +1 -1 +2 +3 -2 +2 -3 -2 +1 -1 +1 -1.
- R5: Profile 2 uses the 8-entry sequence +6 +1 +5 0 -4 -1 -5 -2.
- R6: The block index is address divided by block size, and the phase is that index modulo the sequence length. The output is (index + displacement) times block size plus offset. The phase continues correctly past the first period.
- R7: The byte offset within the block (address modulo block size) is carried to the output unchanged.
- R8: A valid input sampled at a clock edge appears on `out_valid`/`out_addr`/`out_err` after the third rising edge, counting that edge as the first. A new input is accepted every cycle, and idle cycles produce `out_valid` 0.
- R9: If the displaced index is below zero, or the remapped address is at or above 2^ADDR_W, `out_err` is 1 and `out_addr` equals the input address. `out_err` is never 1 for a disabled address.
- R10: Over any full period of the sequence starting at a multiple of its length, the displaced block indices are a permutation of the period's own indices.
- R11: While reset is asserted, `out_valid`, `out_err` and `out_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input address is valid this cycle |
| in_addr | input | ADDR_W | Linear physical address |
| in_flags | input | FLAG_W | Page flags; bit EN_BIT enables remapping |
| in_prof | input | 2 | Profile select |
| out_valid | output | 1 | Output address valid |
| out_addr | output | ADDR_W | Remapped (or passed-through) address |
| out_err | output | 1 | Displacement left the address space; address passed through |

## Verification
The error path is the hardest case to reach from the ports. None of the four sequences ever displaces a block below zero inside a period that starts on an aligned boundary. So the only way to reach the error path is from the very top of the address space, where the last period is cut short and a positive displacement runs past 2^ADDR_W. The stimulus therefore sends the highest addresses under each profile, for example the all-ones address under profile 0, where the phase is 7 and the displacement is +3. The permutation property is checked by sweeping two whole periods per profile back to back and tallying the output block indices.

// File: rtl/blkmap_pkg.sv
package blkmap_pkg;

  localparam int NPROF        = 4;
  localparam int SHIFT_W      = 4;
  localparam int MIN_BLK_LOG2 = 13;
  localparam int OFF_W        = 15;
  localparam int PHASE_W      = 4;

  typedef enum logic [1:0] {
    PROF_A = 2'd0,
    PROF_B = 2'd1,
    PROF_C = 2'd2,
    PROF_D = 2'd3
  } prof_e;

  function automatic int unsigned blk_bytes(input logic [1:0] p);
    case (p)
      2'd0:    return 32'h2000;
      2'd1:    return 32'h4000;
      2'd2:    return 32'h7000;
      default: return 32'h8000;
    endcase
  endfunction

  function automatic int unsigned seq_len(input logic [1:0] p);
    return (p == PROF_C) ? 8 : 12;
  endfunction

  // Sequence shared by profiles A and D.
  function automatic logic signed [SHIFT_W-1:0] seq_ad(input logic [PHASE_W-1:0] ph);
    case (ph)
      4'd0, 4'd2, 4'd4: return 4'sd1;
      4'd1, 4'd3, 4'd5: return -4'sd1;
      4'd6, 4'd9:       return 4'sd2;
      4'd7:             return 4'sd3;
      4'd10:            return -4'sd3;
      default:          return -4'sd2;
    endcase
  endfunction

  function automatic logic signed [SHIFT_W-1:0] seq_b(input logic [PHASE_W-1:0] ph);
    case (ph)
      4'd0, 4'd8, 4'd10: return 4'sd1;
      4'd1, 4'd9, 4'd11: return -4'sd1;
      4'd2, 4'd5:        return 4'sd2;
      4'd3:              return 4'sd3;
      4'd6:              return -4'sd3;
      default:           return -4'sd2;
    endcase
  endfunction

  function automatic logic signed [SHIFT_W-1:0] seq_c(input logic [PHASE_W-1:0] ph);
    case (ph[2:0])
      3'd0:    return 4'sd6;
      3'd1:    return 4'sd1;
      3'd2:    return 4'sd5;
      3'd3:    return 4'sd0;
      3'd4:    return -4'sd4;
      3'd5:    return -4'sd1;
      3'd6:    return -4'sd5;
      default: return -4'sd2;
    endcase
  endfunction

endpackage

// File: rtl/blkmap_split.sv
module blkmap_split
  import blkmap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = ADDR_W - MIN_BLK_LOG2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        prof,
  output logic [IDX_W-1:0]  idx,
  output logic [OFF_W-1:0]  off
);

  logic [IDX_W-1:0] idx_p [NPROF];
  logic [OFF_W-1:0] off_p [NPROF];

  // One constant divider per profile; the power-of-two ones reduce to wiring.
  for (genvar p = 0; p < NPROF; p++) begin : g_div
    localparam logic [ADDR_W-1:0] BS = ADDR_W'(blk_bytes(2'(p)));
    logic [ADDR_W-1:0] quo;
    logic [ADDR_W-1:0] rem;
    assign quo      = addr / BS;
    assign rem      = addr % BS;
    assign idx_p[p] = quo[IDX_W-1:0];
    assign off_p[p] = rem[OFF_W-1:0];
    logic quo_unused;
    assign quo_unused = ^{quo[ADDR_W-1:IDX_W], rem[ADDR_W-1:OFF_W]};
  end

  assign idx = idx_p[prof];
  assign off = off_p[prof];

endmodule

// File: rtl/blkmap_phase.sv
module blkmap_phase
  import blkmap_pkg::*;
#(
  parameter int IDX_W = 19
) (
  input  logic [IDX_W-1:0]          idx,
  input  logic [1:0]                prof,
  output logic [PHASE_W-1:0]        phase,
  output logic signed [SHIFT_W-1:0] shift
);

  logic [IDX_W-1:0]   mod12;
  logic [PHASE_W-1:0] ph12;
  logic [PHASE_W-1:0] ph8;

  assign mod12 = idx % IDX_W'(12);
  assign ph12  = mod12[PHASE_W-1:0];
  assign ph8   = {1'b0, idx[2:0]};

  logic mod_unused;
  assign mod_unused = ^mod12[IDX_W-1:PHASE_W];

  always_comb begin
    case (prof)
      PROF_B: begin
        phase = ph12;
        shift = seq_b(ph12);
      end
      PROF_C: begin
        phase = ph8;
        shift = seq_c(ph8);
      end
      default: begin
        phase = ph12;
        shift = seq_ad(ph12);
      end
    endcase
  end

endmodule

// File: rtl/blkmap_merge.sv
module blkmap_merge
  import blkmap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = ADDR_W - MIN_BLK_LOG2
) (
  input  logic [ADDR_W-1:0]         orig,
  input  logic [IDX_W-1:0]          idx,
  input  logic [OFF_W-1:0]          off,
  input  logic signed [SHIFT_W-1:0] shift,
  input  logic [1:0]                prof,
  output logic [ADDR_W-1:0]         addr,
  output logic                      err
);

  localparam int SUM_W  = IDX_W + 2;
  localparam int WIDE_W = ADDR_W + 2;

  logic signed [SUM_W-1:0] sum;
  logic [WIDE_W-1:0]       wide_p [NPROF];
  logic [WIDE_W-1:0]       wide;
  logic                    below;
  logic                    above;

  assign sum = $signed({2'b00, idx}) +
               $signed({{(SUM_W-SHIFT_W){shift[SHIFT_W-1]}}, shift});

  for (genvar p = 0; p < NPROF; p++) begin : g_mul
    localparam logic [WIDE_W-1:0] BS = WIDE_W'(blk_bytes(2'(p)));
    assign wide_p[p] = WIDE_W'($unsigned(sum)) * BS + WIDE_W'(off);
  end

  assign wide  = wide_p[prof];
  assign below = sum[SUM_W-1];
  assign above = |wide[WIDE_W-1:ADDR_W];

  always_comb begin
    err  = below | above;
    addr = err ? orig : wide[ADDR_W-1:0];
  end

endmodule

// File: rtl/blkmap_top.sv
module blkmap_top
  import blkmap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int FLAG_W = 16,
  parameter int EN_BIT = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [FLAG_W-1:0] in_flags,
  input  logic [1:0]        in_prof,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_err
);

  localparam int IDX_W = ADDR_W - MIN_BLK_LOG2;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic flags_unused;
  assign flags_unused = ^in_flags;

  // Stage 1: split into block index and offset.
  logic [IDX_W-1:0] s1_idx_d;
  logic [OFF_W-1:0] s1_off_d;

  blkmap_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_split (
    .addr (in_addr),
    .prof (in_prof),
    .idx  (s1_idx_d),
    .off  (s1_off_d)
  );

  logic              s1_v, s1_en;
  logic [1:0]        s1_prof;
  logic [IDX_W-1:0]  s1_idx;
  logic [OFF_W-1:0]  s1_off;
  logic [ADDR_W-1:0] s1_addr;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_v    <= 1'b0;
      s1_en   <= 1'b0;
      s1_prof <= 2'd0;
      s1_idx  <= '0;
      s1_off  <= '0;
      s1_addr <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_en   <= in_flags[EN_BIT];
        s1_prof <= in_prof;
        s1_idx  <= s1_idx_d;
        s1_off  <= s1_off_d;
        s1_addr <= in_addr;
      end
    end
  end

  // Stage 2: phase and displacement lookup.
  logic [PHASE_W-1:0]        s2_phase_d;
  logic signed [SHIFT_W-1:0] s2_shift_d;

  blkmap_phase #(.IDX_W(IDX_W)) u_phase (
    .idx   (s1_idx),
    .prof  (s1_prof),
    .phase (s2_phase_d),
    .shift (s2_shift_d)
  );

  logic phase_unused;
  assign phase_unused = ^s2_phase_d;

  logic                      s2_v, s2_en;
  logic [1:0]                s2_prof;
  logic [IDX_W-1:0]          s2_idx;
  logic [OFF_W-1:0]          s2_off;
  logic [ADDR_W-1:0]         s2_addr;
  logic signed [SHIFT_W-1:0] s2_shift;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s2_v     <= 1'b0;
      s2_en    <= 1'b0;
      s2_prof  <= 2'd0;
      s2_idx   <= '0;
      s2_off   <= '0;
      s2_addr  <= '0;
      s2_shift <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        s2_en    <= s1_en;
        s2_prof  <= s1_prof;
        s2_idx   <= s1_idx;
        s2_off   <= s1_off;
        s2_addr  <= s1_addr;
        s2_shift <= s2_shift_d;
      end
    end
  end

  // Stage 3: rebuild the address and range-check it.
  logic [ADDR_W-1:0] mrg_addr;
  logic              mrg_err;

  blkmap_merge #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_merge (
    .orig  (s2_addr),
    .idx   (s2_idx),
    .off   (s2_off),
    .shift (s2_shift),
    .prof  (s2_prof),
    .addr  (mrg_addr),
    .err   (mrg_err)
  );

  logic [ADDR_W-1:0] o_addr_d;
  logic              o_err_d;

  always_comb begin
    if (s2_en) begin
      o_addr_d = mrg_addr;
      o_err_d  = mrg_err;
    end else begin
      o_addr_d = s2_addr;
      o_err_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= s2_v;
      if (s2_v) begin
        out_addr <= o_addr_d;
        out_err  <= o_err_d;
      end else begin
        out_err  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/blkmap_chk.sv
module blkmap_chk
  import blkmap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int FLAG_W = 16,
  parameter int EN_BIT = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [ADDR_W-1:0] in_addr,
  input logic [FLAG_W-1:0] in_flags,
  input logic [1:0]        in_prof,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_err
);

  // Edges seen since reset release, saturating at 3.
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm <= 2'd0;
    else if (warm != 2'd3)  warm <= warm + 2'd1;
  end

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && out_valid && !$past(in_flags[EN_BIT], 3))
      |-> (out_addr == $past(in_addr, 3) && !out_err));

  a_r9_err_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && out_err)
      |-> (out_valid && out_addr == $past(in_addr, 3) && $past(in_flags[EN_BIT], 3)));

  a_r7_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && out_valid)
      |-> ((out_addr % ADDR_W'(blk_bytes($past(in_prof, 3)))) ==
           ($past(in_addr, 3) % ADDR_W'(blk_bytes($past(in_prof, 3))))));

endmodule

bind blkmap_top blkmap_chk #(
  .ADDR_W(ADDR_W), .FLAG_W(FLAG_W), .EN_BIT(EN_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_addr   (in_addr),
  .in_flags  (in_flags),
  .in_prof   (in_prof),
  .out_valid (out_valid),
  .out_addr  (out_addr),
  .out_err   (out_err)
);

// File: tb/blkmap_top_test.sv
`timescale 1ns/1ps
module blkmap_top_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_addr;
  logic [15:0] in_flags;
  logic [1:0]  in_prof;
  logic        out_valid;
  logic [31:0] out_addr;
  logic        out_err;

  always #4 clk = ~clk;

  blkmap_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .in_flags(in_flags), .in_prof(in_prof), .out_valid(out_valid),
    .out_addr(out_addr), .out_err(out_err)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int SEQ_AD [12] = '{1, -1, 1, -1, 1, -1, 2, 3, -2, 2, -3, -2};
  int SEQ_B  [12] = '{1, -1, 2, 3, -2, 2, -3, -2, 1, -1, 1, -1};
  int SEQ_C  [8]  = '{6, 1, 5, 0, -4, -1, -5, -2};

  function automatic longint bsz(int p);
    case (p)
      0: return 64'h2000;
      1: return 64'h4000;
      2: return 64'h7000;
      default: return 64'h8000;
    endcase
  endfunction

  function automatic int plen(int p);
    return (p == 2) ? 8 : 12;
  endfunction

  function automatic int disp(int p, int ph);
    if (p == 1) return SEQ_B[ph];
    if (p == 2) return SEQ_C[ph];
    return SEQ_AD[ph];
  endfunction

  // Reference pipeline, three deep; index 0 is the newest.
  bit          mv  [3];
  logic [31:0] ma  [3];
  logic [31:0] min_a [3];
  bit          me  [3];
  int          mp  [3];
  string       mtag[3];

  bit     collect = 0;
  int     col_prof;
  int     col_cnt [24];
  int     col_out;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input bit v, input logic [31:0] a, input logic [15:0] f,
                       input int p);
    longint idx, off, ni, res;
    for (int k = 2; k > 0; k--) begin
      mv[k] = mv[k-1]; ma[k] = ma[k-1]; me[k] = me[k-1];
      mp[k] = mp[k-1]; mtag[k] = mtag[k-1]; min_a[k] = min_a[k-1];
    end
    mv[0] = v; mp[0] = p; min_a[0] = a;
    if (!f[11]) begin
      ma[0] = a; me[0] = 0; mtag[0] = "R1";
    end else begin
      idx = longint'(a) / bsz(p);
      off = longint'(a) % bsz(p);
      ni  = idx + disp(p, int'(idx % plen(p)));
      res = ni * bsz(p) + off;
      if (ni < 0 || res >= 64'h1_0000_0000) begin
        ma[0] = a; me[0] = 1; mtag[0] = "R9";
      end else begin
        ma[0] = res[31:0]; me[0] = 0;
        if (idx >= plen(p)) mtag[0] = "R6";
        else if (p == 1)    mtag[0] = "R4";
        else if (p == 2)    mtag[0] = "R5";
        else                mtag[0] = "R3";
      end
    end
  endtask

  task automatic compare();
    longint blk;
    if (!mv[2]) begin
      chk(out_valid == 1'b0, "R8", "idle out_valid", out_valid, 0);
      return;
    end
    chk(out_valid == 1'b1, "R8", "out_valid", out_valid, 1);
    chk(out_addr == ma[2], mtag[2], "out_addr", out_addr, ma[2]);
    chk(out_err == me[2], mtag[2], "out_err", out_err, me[2]);
    if (!me[2]) begin
      chk((longint'(out_addr) % bsz(mp[2])) == (longint'(min_a[2]) % bsz(mp[2])),
          "R7", "offset", out_addr, min_a[2]);
      chk(((longint'(out_addr) - longint'(min_a[2])) % bsz(mp[2])) == 0,
          "R2", "block multiple", out_addr, min_a[2]);
    end
    if (collect) begin
      blk = longint'(out_addr) / bsz(col_prof);
      if (blk >= 0 && blk < 2 * plen(col_prof)) col_cnt[blk]++;
      else col_out++;
    end
  endtask

  // Drive one cycle: apply inputs, advance to the next falling edge, check.
  task automatic drive(input bit v, input logic [31:0] a, input logic [15:0] f,
                       input int p);
    in_valid = v; in_addr = a; in_flags = f; in_prof = 2'(p);
    @(negedge clk);
    model(v, a, f, p);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 32'h0, 16'h0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] a;
    logic [15:0] f;
    int p;
    for (int k = 0; k < 3; k++) begin mv[k] = 0; ma[k] = 0; me[k] = 0; mp[k] = 0; min_a[k] = 0; end
    rst_n = 1'b0; in_valid = 0; in_addr = 0; in_flags = 0; in_prof = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(out_valid == 0, "R11", "reset out_valid", out_valid, 0);
    chk(out_err == 0,   "R11", "reset out_err",   out_err,   0);
    chk(out_addr == 0,  "R11", "reset out_addr",  out_addr,  0);
    rst_n = 1'b1;
    idle(4);

    // R1: enable bit clear, all other flags set, every profile
    for (int q = 0; q < 4; q++) begin
      drive(1, 32'h1234_5678 + 32'(q) * 32'h0100_0F00, 16'hF7FF, q);
      drive(1, 32'hFFFF_FFFF, 16'h0000, q);
    end
    idle(4);

    // R3/R4/R5/R6/R10: two full periods per profile, back to back
    for (int q = 0; q < 4; q++) begin
      for (int k = 0; k < 24; k++) col_cnt[k] = 0;
      col_out = 0; col_prof = q; collect = 1;
      for (int k = 0; k < 2 * plen(q); k++)
        drive(1, 32'(longint'(k) * bsz(q) + ((k * 37 + 5) % bsz(q))), 16'h0800, q);
      idle(4);
      collect = 0;
      for (int k = 0; k < 2 * plen(q); k++)
        chk(col_cnt[k] == 1, "R10", $sformatf("prof %0d block %0d hits", q, k), col_cnt[k], 1);
      chk(col_out == 0, "R10", "blocks outside period", col_out, 0);
    end

    // R9: top of the address space
    drive(1, 32'hFFFF_FFFF, 16'h0800, 0);
    idle(3);
    chk(1'b1, "R9", "top address issued", 0, 0);
    for (int q = 0; q < 4; q++)
      for (int k = 0; k < 16; k++)
        drive(1, 32'hFFFF_FFFF - 32'(longint'(k) * bsz(q)), 16'h0800, q);

    // R8: random traffic with bubbles
    for (int i = 0; i < 600; i++) begin
      a = $urandom;
      f = 16'($urandom);
      if (($urandom % 4) != 0) f[11] = 1'b1;
      p = int'($urandom % 4);
      drive(($urandom % 3) != 0, a, f, p);
    end
    idle(5);

    // R11: reset again mid-stream
    drive(1, 32'h0040_0000, 16'h0800, 2);
    rst_n = 1'b0;
    #1;
    chk(out_valid == 0, "R11", "async reset out_valid", out_valid, 0);
    chk(out_addr == 0,  "R11", "async reset out_addr",  out_addr,  0);
    finish_run();
  end

endmodule